// File: doc/BRIEF.md
# Dual-Pointer Indirect Data Access Unit

This unit sits between an 8-bit core's register-file port and its data RAM. It holds two 8-bit pointer registers. Each pointer has a companion virtual window address that has no storage of its own. When the core reads or writes a window address, the access goes instead to the location named by the matching pointer. The core has one read port and one write port, and both are resolved in the same cycle. One instruction can therefore move a byte from one window to the other.

After each access through a window, the pointer behind it can step up, step down or stay where it is. Two mode bits per pointer choose which. A small bank register widens the RAM address when the final address lies in a banked window. Some accesses are degenerate: the pointer names a window address, and a pointer of zero is one such case. A degenerate read returns zero and raises a set-zero strobe. A degenerate write is dropped and raises a status-hold strobe, so the core leaves its flags alone.

Top module: `idx_access_unit`

## Requirements
- R1: The unit maps its own registers at core addresses 0x01 (pointer 0), 0x09 (pointer 1), 0x04 (step modes, low 4 bits) and 0x0F (bank, low 2 bits). Unused upper bits read as zero. Synchronous reset clears both pointers, the modes and the bank, and each reads back as 0x00.
- R2: A read of window 0x00 (or 0x08) returns the byte at the address held in pointer 0 (or pointer 1), in the same cycle. The target may be RAM or one of the unit's own registers.
- R3: A write to window 0x00 (or 0x08) stores the data at the address held in pointer 0 (or pointer 1). A RAM target raises ram_we with that address.
- R4: A final address in 0x10..0x17 reaches RAM address {bank, addr}, with the bank in bits 9:8. Every other address reaches {2'b00, addr}.
- R5: Mode bits 1:0 govern pointer 0 and bits 3:2 govern pointer 1. The encoding is 00 hold, 01 increment, 10 decrement, 11 hold. The pointer takes its new value on the clock edge of each window access, modulo 256. A pointer that wraps to zero raises no z_set.
- R6: If the pointer behind a window read holds 0x00 or 0x08, rd_data is 0x00 and z_set is 1. z_set is 0 in every other cycle. The pointer still steps.
- R7: If the pointer behind a window write holds 0x00 or 0x08, the write changes neither RAM nor any register, and status_hold is 1. status_hold is 0 otherwise.
- R8: A write that lands on a pointer register, directly or through the other window, overrides that pointer's step in the same cycle.
- R9: When the read port uses one window and the write port uses the other in the same cycle, each pointer resolves and steps on its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Core read request |
| rd_addr | input | 8 | Core read address |
| rd_data | output | 8 | Read result, combinational |
| wr_en | input | 1 | Core write request |
| wr_addr | input | 8 | Core write address |
| wr_data | input | 8 | Core write data |
| ram_re | output | 1 | RAM read strobe |
| ram_raddr | output | 10 | RAM read address |
| ram_rdata | input | 8 | RAM read data, same cycle |
| ram_we | output | 1 | RAM write strobe |
| ram_waddr | output | 10 | RAM write address |
| ram_wdata | output | 8 | RAM write data |
| z_set | output | 1 | Degenerate window read: set the zero flag |
| status_hold | output | 1 | Degenerate window write: keep status flags |
| mode_bits | output | 4 | Current step modes of both pointers |

## Verification
The hardest cases to reach from the ports need several register states lined up in one cycle. One is a window access whose pointer points back at a window or at a pointer register while a step mode is active. Another is both ports using different windows while a direct pointer write collides with a step. Directed sequences first load the pointers, modes and bank through ordinary writes and then issue the colliding cycle. A random phase biases pointer values toward 0x00, 0x08, 0xFF and the banked window, and biases addresses toward the unit's own registers, so that these collisions occur often.

// File: rtl/idx_access_pkg.sv
package idx_access_pkg;

    localparam int DATA_W  = 8;
    localparam int ADDR_W  = 8;
    localparam int BANK_W  = 2;
    localparam int RAM_AW  = ADDR_W + BANK_W;
    localparam int NUM_PTR = 2;
    localparam int MODE_W  = 2;
    localparam int MODES_W = NUM_PTR * MODE_W;

    localparam logic [ADDR_W-1:0] A_WIN0    = 8'h00;
    localparam logic [ADDR_W-1:0] A_PTR0    = 8'h01;
    localparam logic [ADDR_W-1:0] A_MODE    = 8'h04;
    localparam logic [ADDR_W-1:0] A_WIN1    = 8'h08;
    localparam logic [ADDR_W-1:0] A_PTR1    = 8'h09;
    localparam logic [ADDR_W-1:0] A_BANK    = 8'h0F;
    localparam logic [ADDR_W-1:0] BANKED_LO = 8'h10;
    localparam logic [ADDR_W-1:0] BANKED_HI = 8'h17;

    typedef enum logic [2:0] {
        T_RAM, T_WIN0, T_WIN1, T_PTR0, T_PTR1, T_MODE, T_BANK
    } tgt_e;

    typedef struct packed {
        tgt_e              kind;
        logic [ADDR_W-1:0] addr;
    } tgt_t;

    typedef enum logic [MODE_W-1:0] {
        M_HOLD = 2'b00, M_INC = 2'b01, M_DEC = 2'b10, M_HOLD_ALT = 2'b11
    } step_e;

    function automatic tgt_e classify(input logic [ADDR_W-1:0] a);
        case (a)
            A_WIN0:  return T_WIN0;
            A_WIN1:  return T_WIN1;
            A_PTR0:  return T_PTR0;
            A_PTR1:  return T_PTR1;
            A_MODE:  return T_MODE;
            A_BANK:  return T_BANK;
            default: return T_RAM;
        endcase
    endfunction

    function automatic logic [ADDR_W-1:0] step_ptr(input logic [ADDR_W-1:0] p,
                                                   input logic [MODE_W-1:0] m);
        case (step_e'(m))
            M_INC:   return p + 1'b1;
            M_DEC:   return p - 1'b1;
            default: return p;
        endcase
    endfunction

    function automatic logic [RAM_AW-1:0] ram_map(input logic [ADDR_W-1:0] a,
                                                  input logic [BANK_W-1:0] bank);
        if (a >= BANKED_LO && a <= BANKED_HI)
            return {bank, a};
        return {{BANK_W{1'b0}}, a};
    endfunction

endpackage

// File: rtl/idx_resolve.sv
module idx_resolve
    import idx_access_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] ptr0,
    input  logic [ADDR_W-1:0] ptr1,
    output tgt_t              tgt,
    output logic              is_win,
    output logic              win_sel,
    output logic              is_null
);
    tgt_e              dir_kind;
    logic [ADDR_W-1:0] pval;

    always_comb begin
        dir_kind = classify(addr);
        is_win   = (dir_kind == T_WIN0) || (dir_kind == T_WIN1);
        win_sel  = (dir_kind == T_WIN1);
        pval     = win_sel ? ptr1 : ptr0;
        if (is_win) begin
            tgt.kind = classify(pval);
            tgt.addr = pval;
        end else begin
            tgt.kind = dir_kind;
            tgt.addr = addr;
        end
        is_null = is_win && ((tgt.kind == T_WIN0) || (tgt.kind == T_WIN1));
    end
endmodule

// File: rtl/idx_ptr_reg.sv
module idx_ptr_reg
    import idx_access_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              step,
    input  logic [MODE_W-1:0] mode,
    output logic [ADDR_W-1:0] ptr
);
    always_ff @(posedge clk) begin
        if (rst)
            ptr <= '0;
        else if (load)
            ptr <= load_val;
        else if (step)
            ptr <= step_ptr(ptr, mode);
    end
endmodule

// File: rtl/idx_access_unit.sv
module idx_access_unit
    import idx_access_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              ram_re,
    output logic [RAM_AW-1:0] ram_raddr,
    input  logic [DATA_W-1:0] ram_rdata,
    output logic              ram_we,
    output logic [RAM_AW-1:0] ram_waddr,
    output logic [DATA_W-1:0] ram_wdata,
    output logic              z_set,
    output logic              status_hold,
    output logic [MODES_W-1:0] mode_bits
);
    logic [ADDR_W-1:0]  ptr_q [NUM_PTR];
    logic [ADDR_W-1:0]  ptr0_q, ptr1_q;
    logic [MODES_W-1:0] mode_q;
    logic [BANK_W-1:0]  bank_q;

    tgt_t rd_tgt, wr_tgt;
    logic rd_win, rd_sel, rd_null;
    logic wr_win, wr_sel, wr_null;
    logic wr_ok;

    assign ptr0_q = ptr_q[0];
    assign ptr1_q = ptr_q[1];

    idx_resolve u_rd_res (
        .addr(rd_addr), .ptr0(ptr0_q), .ptr1(ptr1_q),
        .tgt(rd_tgt), .is_win(rd_win), .win_sel(rd_sel), .is_null(rd_null)
    );

    idx_resolve u_wr_res (
        .addr(wr_addr), .ptr0(ptr0_q), .ptr1(ptr1_q),
        .tgt(wr_tgt), .is_win(wr_win), .win_sel(wr_sel), .is_null(wr_null)
    );

    assign wr_ok = wr_en && !wr_null;

    for (genvar n = 0; n < NUM_PTR; n++) begin : g_ptr
        logic do_step, do_load;
        localparam tgt_e PTR_KIND = (n == 0) ? T_PTR0 : T_PTR1;
        assign do_step = (rd_en && rd_win && (rd_sel == n[0]))
                      || (wr_en && wr_win && (wr_sel == n[0]));
        assign do_load = wr_ok && (wr_tgt.kind == PTR_KIND);
        idx_ptr_reg u_ptr (
            .clk(clk), .rst(rst),
            .load(do_load), .load_val(wr_data),
            .step(do_step), .mode(mode_q[n*MODE_W +: MODE_W]),
            .ptr(ptr_q[n])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
            bank_q <= '0;
        end else if (wr_ok) begin
            if (wr_tgt.kind == T_MODE) mode_q <= wr_data[MODES_W-1:0];
            if (wr_tgt.kind == T_BANK) bank_q <= wr_data[BANK_W-1:0];
        end
    end

    always_comb begin
        case (rd_tgt.kind)
            T_RAM:   rd_data = ram_rdata;
            T_PTR0:  rd_data = ptr0_q;
            T_PTR1:  rd_data = ptr1_q;
            T_MODE:  rd_data = {{(DATA_W-MODES_W){1'b0}}, mode_q};
            T_BANK:  rd_data = {{(DATA_W-BANK_W){1'b0}}, bank_q};
            default: rd_data = '0;
        endcase
    end

    assign ram_re      = rd_en && (rd_tgt.kind == T_RAM);
    assign ram_raddr   = ram_map(rd_tgt.addr, bank_q);
    assign ram_we      = wr_ok && (wr_tgt.kind == T_RAM);
    assign ram_waddr   = ram_map(wr_tgt.addr, bank_q);
    assign ram_wdata   = wr_data;
    assign z_set       = rd_en && rd_null;
    assign status_hold = wr_en && wr_null;
    assign mode_bits   = mode_q;
endmodule

// File: rtl/idx_access_unit_chk.sv
module idx_access_unit_chk
    import idx_access_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               rd_en,
    input logic [ADDR_W-1:0]  rd_addr,
    input logic [DATA_W-1:0]  rd_data,
    input logic               wr_en,
    input logic [ADDR_W-1:0]  wr_addr,
    input logic [DATA_W-1:0]  wr_data,
    input logic               ram_we,
    input logic               z_set,
    input logic               status_hold,
    input logic [MODES_W-1:0] mode_bits,
    input logic [ADDR_W-1:0]  ptr0_q,
    input logic [ADDR_W-1:0]  ptr1_q
);
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (ptr0_q == '0 && ptr1_q == '0 && mode_bits == '0));

    p_inc_step_r5: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_addr == A_WIN0 && !wr_en && mode_bits[1:0] == 2'b01)
        |=> ptr0_q == $past(ptr0_q) + 8'd1);

    p_hold_mode_r5: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && (mode_bits[3:2] == 2'b00 || mode_bits[3:2] == 2'b11))
        |=> $stable(ptr1_q));

    p_null_read_zero_r6: assert property (@(posedge clk) disable iff (rst)
        z_set |-> (rd_data == '0));

    p_zset_window_only_r6: assert property (@(posedge clk) disable iff (rst)
        z_set |-> (rd_en && (rd_addr == A_WIN0 || rd_addr == A_WIN1)));

    p_null_write_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        status_hold |-> !ram_we);

    p_load_beats_step_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == A_PTR0) |=> ptr0_q == $past(wr_data));
endmodule

bind idx_access_unit idx_access_unit_chk u_chk (
    .clk(clk), .rst(rst), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .ram_we(ram_we),
    .z_set(z_set), .status_hold(status_hold), .mode_bits(mode_bits),
    .ptr0_q(ptr0_q), .ptr1_q(ptr1_q)
);

// File: tb/idx_access_unit_tb.sv
`timescale 1ns/1ps
module idx_access_unit_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rd_en = 1'b0, wr_en = 1'b0;
    logic [7:0] rd_addr = '0, wr_addr = '0, wr_data = '0;
    logic [7:0] rd_data, ram_rdata, ram_wdata;
    logic [9:0] ram_raddr, ram_waddr;
    logic       ram_re, ram_we, z_set, status_hold;
    logic [3:0] mode_bits;

    logic [7:0] mem [1024];
    logic [7:0] exp_mem [1024];
    logic [7:0] m_ptr [2];
    logic [3:0] m_mode;
    logic [1:0] m_bank;
    int checks = 0, fails = 0;

    always #2.5 clk = ~clk;

    idx_access_unit u_dut (
        .clk(clk), .rst(rst), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .ram_re(ram_re), .ram_raddr(ram_raddr), .ram_rdata(ram_rdata),
        .ram_we(ram_we), .ram_waddr(ram_waddr), .ram_wdata(ram_wdata),
        .z_set(z_set), .status_hold(status_hold), .mode_bits(mode_bits)
    );

    assign ram_rdata = mem[ram_raddr];
    always @(posedge clk) if (ram_we) mem[ram_waddr] <= ram_wdata;

    // kinds: 0 ram, 1 win0, 2 win1, 3 ptr0, 4 ptr1, 5 mode, 6 bank
    function automatic int kind_of(input logic [7:0] a);
        case (a)
            8'h00: return 1;  8'h08: return 2;
            8'h01: return 3;  8'h09: return 4;
            8'h04: return 5;  8'h0F: return 6;
            default: return 0;
        endcase
    endfunction

    function automatic logic [9:0] phys(input logic [7:0] a);
        if (a >= 8'h10 && a <= 8'h17) return {m_bank, a};
        return {2'b00, a};
    endfunction

    function automatic logic [7:0] next_ptr(input logic [7:0] p, input logic [1:0] m);
        if (m == 2'b01) return p + 8'd1;
        if (m == 2'b10) return p - 8'd1;
        return p;
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%02h expected=%02h", tag, what, act, exp);
        end
    endtask

    task automatic cyc(input logic re, input logic [7:0] ra,
                       input logic we, input logic [7:0] wa, input logic [7:0] wd,
                       input string tag);
        int rk, wk, rwin, wwin;
        logic [7:0] rt, wt, er;
        logic rnull, wnull;
        logic [7:0] np [2];
        logic [3:0] nmode;
        logic [1:0] nbank;
        @(negedge clk);
        rd_en = re; rd_addr = ra; wr_en = we; wr_addr = wa; wr_data = wd;
        #1;
        rwin = kind_of(ra); rt = ra;
        if (rwin == 1 || rwin == 2) rt = m_ptr[rwin-1];
        rk = kind_of(rt);
        rnull = (rwin == 1 || rwin == 2) && (rk == 1 || rk == 2);
        wwin = kind_of(wa); wt = wa;
        if (wwin == 1 || wwin == 2) wt = m_ptr[wwin-1];
        wk = kind_of(wt);
        wnull = (wwin == 1 || wwin == 2) && (wk == 1 || wk == 2);
        case (rk)
            0: er = exp_mem[phys(rt)];
            3: er = m_ptr[0];
            4: er = m_ptr[1];
            5: er = {4'h0, m_mode};
            6: er = {6'h0, m_bank};
            default: er = 8'h00;
        endcase
        if (re) chk(tag, "rd_data", rd_data, er);
        chk("R6", "z_set", {7'h0, z_set}, {7'h0, re && rnull});
        chk("R7", "status_hold", {7'h0, status_hold}, {7'h0, we && wnull});
        chk("R3", "ram_we", {7'h0, ram_we}, {7'h0, we && !wnull && wk == 0});
        np[0] = m_ptr[0]; np[1] = m_ptr[1]; nmode = m_mode; nbank = m_bank;
        for (int n = 0; n < 2; n++)
            if ((re && rwin == n+1) || (we && wwin == n+1))
                np[n] = next_ptr(m_ptr[n], m_mode[2*n +: 2]);
        if (we && !wnull) begin
            case (wk)
                0: exp_mem[phys(wt)] = wd;
                3: np[0] = wd;
                4: np[1] = wd;
                5: nmode = wd[3:0];
                6: nbank = wd[1:0];
                default: ;
            endcase
        end
        @(posedge clk);
        m_ptr[0] = np[0]; m_ptr[1] = np[1]; m_mode = nmode; m_bank = nbank;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        cyc(1'b0, 8'h00, 1'b1, a, d, "R1");
    endtask

    task automatic rd(input logic [7:0] a, input string tag);
        cyc(1'b1, a, 1'b0, 8'h00, 8'h00, tag);
    endtask

    function automatic logic [7:0] pick_addr();
        int r = $urandom % 10;
        case (r)
            0, 1: return 8'h00;
            2:    return 8'h08;
            3:    return ($urandom % 2) ? 8'h01 : 8'h09;
            4:    return 8'h04;
            5:    return 8'h0F;
            6:    return 8'h10 + 8'($urandom % 8);
            default: return 8'($urandom);
        endcase
    endfunction

    function automatic logic [7:0] pick_data();
        int r = $urandom % 8;
        case (r)
            0: return 8'h00;
            1: return 8'h08;
            2: return 8'hFF;
            3: return 8'h10 + 8'($urandom % 8);
            default: return 8'($urandom);
        endcase
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog all requirements actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4321));
        for (int i = 0; i < 1024; i++) begin mem[i] = 8'h00; exp_mem[i] = 8'h00; end
        m_ptr[0] = 8'h00; m_ptr[1] = 8'h00; m_mode = 4'h0; m_bank = 2'b00;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R1 reset state
        rd(8'h01, "R1"); rd(8'h09, "R1"); rd(8'h04, "R1"); rd(8'h0F, "R1");
        chk("R1", "mode_bits", {4'h0, mode_bits}, 8'h00);
        // R6 null read with zero pointer; R7 null write
        rd(8'h00, "R6");
        cyc(1'b0, 8'h00, 1'b1, 8'h08, 8'h5A, "R7");
        rd(8'h09, "R7"); rd(8'h01, "R7");
        // R2 / R3 window access to RAM
        wr(8'h01, 8'h30); wr(8'h30, 8'hA5);
        rd(8'h00, "R2");
        cyc(1'b0, 8'h00, 1'b1, 8'h00, 8'h3C, "R3");
        rd(8'h30, "R3");
        // R2 window onto own register
        wr(8'h09, 8'h01); rd(8'h08, "R2");
        // R4 banking
        wr(8'h0F, 8'h02); wr(8'h09, 8'h12);
        cyc(1'b0, 8'h00, 1'b1, 8'h08, 8'h77, "R4");
        wr(8'h0F, 8'h00); rd(8'h12, "R4");
        wr(8'h0F, 8'h02); rd(8'h12, "R4"); rd(8'h0F, "R4");
        // R5 increment wrap, no z_set
        wr(8'h04, 8'h01); wr(8'h01, 8'hFF);
        rd(8'h00, "R5"); rd(8'h01, "R5");
        // R5 decrement of pointer 1 on a null read (R6)
        wr(8'h04, 8'h08); wr(8'h09, 8'h00);
        rd(8'h08, "R6"); rd(8'h09, "R5");
        // R6 self reference through 0x08
        wr(8'h04, 8'h00); wr(8'h01, 8'h08); rd(8'h00, "R6");
        // R8 direct pointer write beats step
        wr(8'h04, 8'h01); wr(8'h01, 8'h40);
        cyc(1'b1, 8'h00, 1'b1, 8'h01, 8'h55, "R8");
        rd(8'h01, "R8");
        // R8 via the other window
        wr(8'h09, 8'h01);
        cyc(1'b1, 8'h00, 1'b1, 8'h08, 8'h66, "R8");
        rd(8'h01, "R8");
        // R9 both windows in one cycle
        wr(8'h04, 8'h09); wr(8'h01, 8'h20); wr(8'h09, 8'h28); wr(8'h20, 8'hC3);
        cyc(1'b1, 8'h00, 1'b1, 8'h08, 8'h9E, "R9");
        rd(8'h01, "R9"); rd(8'h09, "R9"); rd(8'h28, "R9");

        // random phase
        for (int i = 0; i < 4000; i++) begin
            logic re, we;
            logic [7:0] ra, wa;
            re = ($urandom % 4) != 0;
            we = ($urandom % 3) != 0;
            ra = pick_addr();
            wa = pick_addr();
            cyc(re, ra, we, wa, pick_data(), "R2");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule